// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register store of a processor core that switches between seven operating modes. Software always sees sixteen numbered 32-bit registers. Some of those numbers land on physical copies that belong only to the current mode. An interrupt handler can therefore use its own stack pointer and return-address register without saving the interrupted program's copies first. The store holds 31 physical general registers. Next to them sit one status word shared by every mode and five saved status words, one for each exception mode.

There are two combinational read ports and one write port that commits on the clock edge. Each port carries a 4-bit register number, which is resolved through the current mode code. A per-port override makes that one port resolve through another mode's bank instead; a mode-switch or context-save routine uses it. Every access is a random-access lookup, not a stream, so all pins are plain control and data with no valid/ready handshake. The bench reads a port's data in the same cycle as its address.

Top module: `banked_regfile`

## Requirements
- R1: The 3-bit mode code reads 0 user, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined and 6 system. Code 7 is not a mode and behaves exactly as user.
- R2: Registers 0 to 7 and register 15 (the program counter) are the same physical registers in every mode.
- R3: System mode sees exactly the sixteen registers that user mode sees.
- R4: Fast-interrupt mode has private copies of registers 8 to 14. A write to any of them there is invisible from every other mode, and the reverse also holds.
- R5: Supervisor, abort, undefined and interrupt modes each have private copies of registers 13 (stack pointer) and 14 (link register) only. In these modes, registers 8 to 12 are the user-mode copies.
- R6: When a port's override enable is high, that port resolves its register number through the port's override mode code instead of the current mode. The other ports are not affected.
- R7: A write lands at the next rising clock edge. A read of the same physical register in the cycle of the write returns the old value, and the new value appears from the following cycle.
- R8: The current status word is a single register for all modes. It is loaded from its write data at the clock edge when its write enable is high, and it reads back unchanged whatever the mode.
- R9: The saved-status port addresses the word that belongs to the current mode. Each of the five exception modes has its own word. In user or system mode, reads return zero and writes change nothing.
- R10: An active-low reset clears every general, current-status and saved-status register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_mode | input | 3 | Current mode code |
| ra_num | input | 4 | Read port A register number |
| ra_ovr_en | input | 1 | Read port A uses ra_ovr_mode |
| ra_ovr_mode | input | 3 | Read port A override mode code |
| ra_data | output | 32 | Read port A data |
| rb_num | input | 4 | Read port B register number |
| rb_ovr_en | input | 1 | Read port B uses rb_ovr_mode |
| rb_ovr_mode | input | 3 | Read port B override mode code |
| rb_data | output | 32 | Read port B data |
| w_en | input | 1 | Write port enable |
| w_num | input | 4 | Write port register number |
| w_ovr_en | input | 1 | Write port uses w_ovr_mode |
| w_ovr_mode | input | 3 | Write port override mode code |
| w_data | input | 32 | Write port data |
| cs_we | input | 1 | Current status write enable |
| cs_wdata | input | 32 | Current status write data |
| cs_rdata | output | 32 | Current status read data |
| ss_we | input | 1 | Saved status write enable (current mode) |
| ss_wdata | input | 32 | Saved status write data |
| ss_rdata | output | 32 | Saved status read data (current mode) |

## Verification
The bench builds the block with its defaults: 32-bit data and the fast-interrupt bank starting at register 8. That gives 31 physical registers, so every one of them, including the last interrupt-mode link register, can be reached with a handful of random writes. Random mode codes include the unused code 7. The independent overrides on all three ports mean a write in one bank and a read through another often meet in the same cycle, which tests the old-value rule on shared and private registers alike.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  typedef enum logic [2:0] {
    MD_USR = 3'd0,
    MD_FIQ = 3'd1,
    MD_IRQ = 3'd2,
    MD_SVC = 3'd3,
    MD_ABT = 3'd4,
    MD_UND = 3'd5,
    MD_SYS = 3'd6,
    MD_RSV = 3'd7
  } mode_e;

  localparam int ARCH_N  = 16;  // numbered registers visible at once
  localparam int XBANK_N = 4;   // exception modes with two private regs
  localparam int XREGS   = 2;   // private regs per such mode (13, 14)
  localparam int SAVED_N = 5;   // saved status words
  localparam int PC_NUM  = 15;
  localparam int SP_NUM  = 13;

  // Bank actually used by a mode code: system and the spare code use user's.
  function automatic mode_e bank_of(logic [2:0] code);
    mode_e m;
    m = mode_e'(code);
    if (m == MD_SYS || m == MD_RSV) m = MD_USR;
    return m;
  endfunction

endpackage

// File: rtl/mbrf_bank_map.sv
module mbrf_bank_map
  import mbrf_pkg::*;
#(
  parameter int FIQ_FIRST = 8,
  parameter int PHYS_W    = 5
) (
  input  logic [2:0]        mode_code,
  input  logic [3:0]        num,
  output logic [PHYS_W-1:0] phys_idx
);

  localparam int FIQ_N    = PC_NUM - FIQ_FIRST;
  localparam int FIQ_BASE = ARCH_N;
  localparam int XBASE    = FIQ_BASE + FIQ_N;

  mode_e bank;
  int    slot;
  int    idx_i;

  always_comb begin
    bank  = bank_of(mode_code);
    slot  = 0;
    idx_i = int'(num);
    unique case (bank)
      MD_SVC: slot = 0;
      MD_ABT: slot = 1;
      MD_UND: slot = 2;
      MD_IRQ: slot = 3;
      default: slot = 0;
    endcase
    if (bank == MD_FIQ) begin
      if (int'(num) >= FIQ_FIRST && int'(num) != PC_NUM)
        idx_i = FIQ_BASE + int'(num) - FIQ_FIRST;
    end else if (bank != MD_USR) begin
      if (int'(num) == SP_NUM || int'(num) == SP_NUM + 1)
        idx_i = XBASE + XREGS * slot + int'(num) - SP_NUM;
    end
    phys_idx = PHYS_W'(idx_i);
  end

endmodule

// File: rtl/mbrf_gpr_store.sv
module mbrf_gpr_store #(
  parameter int DATA_W = 32,
  parameter int PHYS_N = 31,
  parameter int NRD    = 2,
  localparam int PHYS_W = $clog2(PHYS_N)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [PHYS_W-1:0]           widx,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NRD-1:0][PHYS_W-1:0]  ridx,
  output logic [NRD-1:0][DATA_W-1:0]  rdata
);

  logic [DATA_W-1:0] mem [PHYS_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_N; i++) mem[i] <= '0;
    end else if (we && int'(widx) < PHYS_N) begin
      mem[widx] <= wdata;
    end
  end

  // Reads see the array before the edge: no bypass of the write port.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (int'(ridx[p]) < PHYS_N) ? mem[ridx[p]] : '0;
  end

endmodule

// File: rtl/mbrf_psr_bank.sv
module mbrf_psr_bank
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_code,
  input  logic              cs_we,
  input  logic [DATA_W-1:0] cs_wdata,
  output logic [DATA_W-1:0] cs_rdata,
  input  logic              ss_we,
  input  logic [DATA_W-1:0] ss_wdata,
  output logic [DATA_W-1:0] ss_rdata
);

  localparam int SLOT_W = $clog2(SAVED_N);

  logic [DATA_W-1:0]                cur_q;
  logic [SAVED_N-1:0][DATA_W-1:0]   saved_q;
  logic [SLOT_W-1:0]                slot;
  logic                             has_saved;

  always_comb begin
    has_saved = 1'b1;
    slot      = '0;
    unique case (bank_of(mode_code))
      MD_FIQ: slot = SLOT_W'(0);
      MD_IRQ: slot = SLOT_W'(1);
      MD_SVC: slot = SLOT_W'(2);
      MD_ABT: slot = SLOT_W'(3);
      MD_UND: slot = SLOT_W'(4);
      default: has_saved = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      saved_q <= '0;
    end else begin
      if (cs_we) cur_q <= cs_wdata;
      if (ss_we && has_saved) saved_q[slot] <= ss_wdata;
    end
  end

  assign cs_rdata = cur_q;
  assign ss_rdata = has_saved ? saved_q[slot] : '0;

  AST_CS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_we |=> cs_rdata == $past(cs_wdata)); // R8
  AST_SS_USR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_we && !has_saved) |=> $stable(saved_q)); // R9
  AST_SS_USR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_of(mode_code) == MD_USR) |-> ss_rdata == '0); // R9

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import mbrf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int FIQ_FIRST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cur_mode,
  input  logic [3:0]        ra_num,
  input  logic              ra_ovr_en,
  input  logic [2:0]        ra_ovr_mode,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_num,
  input  logic              rb_ovr_en,
  input  logic [2:0]        rb_ovr_mode,
  output logic [DATA_W-1:0] rb_data,
  input  logic              w_en,
  input  logic [3:0]        w_num,
  input  logic              w_ovr_en,
  input  logic [2:0]        w_ovr_mode,
  input  logic [DATA_W-1:0] w_data,
  input  logic              cs_we,
  input  logic [DATA_W-1:0] cs_wdata,
  output logic [DATA_W-1:0] cs_rdata,
  input  logic              ss_we,
  input  logic [DATA_W-1:0] ss_wdata,
  output logic [DATA_W-1:0] ss_rdata
);

  localparam int NRD    = 2;
  localparam int FIQ_N  = PC_NUM - FIQ_FIRST;
  localparam int PHYS_N = ARCH_N + FIQ_N + XBANK_N * XREGS;
  localparam int PHYS_W = $clog2(PHYS_N);

  logic [NRD-1:0][3:0]        rnum;
  logic [NRD-1:0][2:0]        rmode;
  logic [NRD-1:0][PHYS_W-1:0] ridx;
  logic [NRD-1:0][DATA_W-1:0] rdat;
  logic [2:0]                 wmode;
  logic [PHYS_W-1:0]          widx;

  assign rnum[0]  = ra_num;
  assign rnum[1]  = rb_num;
  assign rmode[0] = ra_ovr_en ? ra_ovr_mode : cur_mode;
  assign rmode[1] = rb_ovr_en ? rb_ovr_mode : cur_mode;
  assign wmode    = w_ovr_en  ? w_ovr_mode  : cur_mode;

  for (genvar p = 0; p < NRD; p++) begin : g_rmap
    mbrf_bank_map #(.FIQ_FIRST(FIQ_FIRST), .PHYS_W(PHYS_W)) u_map (
      .mode_code (rmode[p]),
      .num       (rnum[p]),
      .phys_idx  (ridx[p])
    );
  end

  mbrf_bank_map #(.FIQ_FIRST(FIQ_FIRST), .PHYS_W(PHYS_W)) u_wmap (
    .mode_code (wmode),
    .num       (w_num),
    .phys_idx  (widx)
  );

  mbrf_gpr_store #(.DATA_W(DATA_W), .PHYS_N(PHYS_N), .NRD(NRD)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (w_en),
    .widx  (widx),
    .wdata (w_data),
    .ridx  (ridx),
    .rdata (rdat)
  );

  assign ra_data = rdat[0];
  assign rb_data = rdat[1];

  mbrf_psr_bank #(.DATA_W(DATA_W)) u_psr (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_code (cur_mode),
    .cs_we     (cs_we),
    .cs_wdata  (cs_wdata),
    .cs_rdata  (cs_rdata),
    .ss_we     (ss_we),
    .ss_wdata  (ss_wdata),
    .ss_rdata  (ss_rdata)
  );

  AST_LOW_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_num == rb_num && (ra_num < 4'd8 || ra_num == 4'd15)) |-> ra_data == rb_data); // R2
  AST_SYS_AS_USR: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_num == rb_num && rmode[0] == MD_SYS && rmode[1] == MD_USR) |-> ra_data == rb_data); // R3
  AST_FIQ_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_num == rb_num && ra_num >= 4'(FIQ_FIRST) && ra_num != 4'd15 &&
     bank_of(rmode[0]) == MD_FIQ && bank_of(rmode[1]) != MD_FIQ) |-> ridx[0] != ridx[1]); // R4
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    w_en |=> (ridx[0] != $past(widx) || ra_data == $past(w_data))); // R7

endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cur_mode = '0;
  logic [3:0]  ra_num = '0, rb_num = '0, w_num = '0;
  logic        ra_ovr_en = 1'b0, rb_ovr_en = 1'b0, w_ovr_en = 1'b0;
  logic [2:0]  ra_ovr_mode = '0, rb_ovr_mode = '0, w_ovr_mode = '0;
  logic        w_en = 1'b0, cs_we = 1'b0, ss_we = 1'b0;
  logic [31:0] w_data = '0, cs_wdata = '0, ss_wdata = '0;
  logic [31:0] ra_data, rb_data, cs_rdata, ss_rdata;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_gpr [31];
  logic [31:0] m_cs;
  logic [31:0] m_ss [5];

  always #2 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
    .ra_num(ra_num), .ra_ovr_en(ra_ovr_en), .ra_ovr_mode(ra_ovr_mode), .ra_data(ra_data),
    .rb_num(rb_num), .rb_ovr_en(rb_ovr_en), .rb_ovr_mode(rb_ovr_mode), .rb_data(rb_data),
    .w_en(w_en), .w_num(w_num), .w_ovr_en(w_ovr_en), .w_ovr_mode(w_ovr_mode), .w_data(w_data),
    .cs_we(cs_we), .cs_wdata(cs_wdata), .cs_rdata(cs_rdata),
    .ss_we(ss_we), .ss_wdata(ss_wdata), .ss_rdata(ss_rdata)
  );

  // Physical slot in the bench's own numbering.
  function automatic int ref_phys(logic [2:0] md, logic [3:0] n);
    int m;
    m = (md == 3'd6 || md == 3'd7) ? 0 : int'(md);
    if (n == 4'd15) return 15;
    if (m == 1 && n >= 4'd8) return 16 + int'(n) - 8;
    if (m >= 2 && n >= 4'd13) begin
      case (m)
        3: return 23 + int'(n) - 13;
        4: return 25 + int'(n) - 13;
        5: return 27 + int'(n) - 13;
        default: return 29 + int'(n) - 13;
      endcase
    end
    return int'(n);
  endfunction

  function automatic int ref_slot(logic [2:0] md);
    case (md)
      3'd1: return 0;
      3'd2: return 1;
      3'd3: return 2;
      3'd4: return 3;
      3'd5: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 31; i++) m_gpr[i] = '0;
    for (int i = 0; i < 5; i++) m_ss[i] = '0;
    m_cs = '0;
  endtask

  // One cycle: drive at the falling edge, check before the rising edge, update model after it.
  task automatic step(string tag, logic [2:0] cm,
                      logic [3:0] an, logic ao, logic [2:0] am,
                      logic [3:0] bn, logic bo, logic [2:0] bm,
                      logic we, logic [3:0] wn, logic wo, logic [2:0] wm, logic [31:0] wd,
                      logic cwe, logic [31:0] cwd, logic swe, logic [31:0] swd);
    int sl;
    cur_mode = cm;
    ra_num = an; ra_ovr_en = ao; ra_ovr_mode = am;
    rb_num = bn; rb_ovr_en = bo; rb_ovr_mode = bm;
    w_en = we; w_num = wn; w_ovr_en = wo; w_ovr_mode = wm; w_data = wd;
    cs_we = cwe; cs_wdata = cwd; ss_we = swe; ss_wdata = swd;
    #1;
    chk({tag, " port A"}, ra_data, m_gpr[ref_phys(ao ? am : cm, an)]);
    chk({tag, " port B"}, rb_data, m_gpr[ref_phys(bo ? bm : cm, bn)]);
    chk({tag, " R8 status"}, cs_rdata, m_cs);
    sl = ref_slot(cm);
    chk({tag, " R9 saved"}, ss_rdata, (sl < 0) ? 32'h0 : m_ss[sl]);
    @(posedge clk);
    if (we) m_gpr[ref_phys(wo ? wm : cm, wn)] = wd;
    if (cwe) m_cs = cwd;
    if (swe && sl >= 0) m_ss[sl] = swd;
    @(negedge clk);
  endtask

  task automatic rd(string tag, logic [2:0] cm, logic [3:0] an, logic [3:0] bn);
    step(tag, cm, an, 0, 0, bn, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(string tag, logic [2:0] cm, logic [3:0] n, logic [31:0] d);
    step(tag, cm, n, 0, 0, n, 0, 0, 1, n, 0, 0, d, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: everything zero after reset, in several banks
    for (int n = 0; n < 16; n++) begin
      rd("R10 reset usr", 3'd0, 4'(n), 4'(n));
      rd("R10 reset fiq", 3'd1, 4'(n), 4'(n));
      rd("R10 reset irq", 3'd2, 4'(n), 4'(n));
    end

    // R4: fast-interrupt private 8..14
    wr("R4 fiq write", 3'd1, 4'd10, 32'hF1F1_0010);
    wr("R4 usr write", 3'd0, 4'd10, 32'hAAAA_0010);
    rd("R4 fiq r10", 3'd1, 4'd10, 4'd14);
    rd("R4 usr r10", 3'd0, 4'd10, 4'd14);

    // R5: svc private 13/14, shares 8..12 with user
    wr("R5 svc sp", 3'd3, 4'd13, 32'h5555_0013);
    rd("R5 usr sp", 3'd0, 4'd13, 4'd10);
    rd("R5 svc sp", 3'd3, 4'd13, 4'd10);
    rd("R5 abt sp", 3'd4, 4'd13, 4'd14);
    wr("R5 und lr", 3'd5, 4'd14, 32'h0E0E_0014);
    rd("R5 irq lr", 3'd2, 4'd14, 4'd12);

    // R3: system shares user bank
    wr("R3 sys lr", 3'd6, 4'd14, 32'h5A5A_0014);
    rd("R3 usr lr", 3'd0, 4'd14, 4'd13);

    // R1: code 7 aliases user
    rd("R1 code7 lr", 3'd7, 4'd14, 4'd10);
    wr("R1 code7 write", 3'd7, 4'd9, 32'h7777_0009);
    rd("R1 usr r9", 3'd0, 4'd9, 4'd9);

    // R6: override write into interrupt sp from user mode, override read back
    step("R6 ovr write", 3'd0, 4'd13, 0, 0, 4'd13, 1, 3'd2,
         1, 4'd13, 1, 3'd2, 32'h1B1B_0013, 0, 0, 0, 0);
    step("R6 ovr read", 3'd0, 4'd13, 1, 3'd2, 4'd13, 0, 0,
         0, 0, 0, 0, 0, 0, 0, 0, 0);
    rd("R6 irq own", 3'd2, 4'd13, 4'd13);

    // R7: same-cycle read returns old value, new value next cycle
    wr("R7 first", 3'd0, 4'd5, 32'h0000_5555);
    wr("R7 same cycle", 3'd0, 4'd5, 32'h1234_5678);
    rd("R7 next cycle", 3'd0, 4'd5, 4'd5);

    // R2: program counter shared
    wr("R2 und pc", 3'd5, 4'd15, 32'h0000_1000);
    rd("R2 fiq pc", 3'd1, 4'd15, 4'd3);

    // R8: status written in one mode, read in another
    step("R8 cs write", 3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hC0DE_0001, 0, 0);
    rd("R8 cs read", 3'd1, 4'd0, 4'd1);

    // R9: saved status per mode, user/system ignored
    step("R9 ss usr", 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF);
    step("R9 ss sys", 3'd6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF);
    for (int m = 0; m < 8; m++) rd("R9 ss sweep", 3'(m), 4'd0, 4'd0);
    step("R9 ss svc", 3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h5050_0003);
    step("R9 ss fiq", 3'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hF0F0_0001);
    for (int m = 0; m < 8; m++) rd("R9 ss sweep2", 3'(m), 4'd0, 4'd0);

    // Random mix across all requirements
    for (int i = 0; i < 3000; i++) begin
      step("R1 R6 R7 random", 3'($urandom),
           4'($urandom), 1'($urandom), 3'($urandom),
           4'($urandom), 1'($urandom), 3'($urandom),
           1'($urandom), 4'($urandom), 1'($urandom), 3'($urandom), $urandom,
           ($urandom % 4) == 0, $urandom, ($urandom % 3) == 0, $urandom);
    end

    // R10: reset in mid-run clears everything again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    for (int n = 0; n < 16; n++) rd("R10 re-reset fiq/usr", 3'd1, 4'(n), 4'(n));
    for (int m = 0; m < 8; m++) rd("R10 re-reset ss", 3'(m), 4'd13, 4'd14);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule